// File: doc/BRIEF.md
# SPI Command Front End with Register File

This block is the slave side of a byte-oriented SPI control channel. An external master frames each command with an active-low select. The first byte after select falls is an opcode. The block decodes it and then gives access to a ten-entry register file, switches the serial bit order, returns a two-byte BCD revision code, or passes the whole command on to a separate I2C transaction engine.

The serial pins are not treated as clocks. Clock, data and select pass through synchronizer flops into the system clock domain. The block samples MOSI on the rising serial-clock edge and changes MISO on the falling edge, so the serial clock idles high. Register reads and writes never involve the engine, so they can be issued while the engine is busy. The engine sees a plain byte stream with a first-byte flag and an end pulse.

Top module: `spi_cmd_regif`

## Requirements
- R1: After reset the I2C clock divider register (address 0x02) holds 0xA0 and every other register holds 0x00.
- R2: The sequence 0x20, address, value writes that value into the one addressed register and changes no other register.
- R3: The sequence 0x21, address, one ignored byte returns the addressed register value on MISO during the fourth byte of the frame.
- R4: The sequence 0x18, 0x42 switches both directions to least-significant-bit first, and 0x18, 0x81 switches them back to most-significant-bit first. Any other second byte leaves the order unchanged. The order takes effect from the next byte.
- R5: The sequence 0x40, one ignored byte returns the revision 0x01 then 0x44 on MISO in the third and fourth bytes.
- R6: Writes to address 0x04 (status) and 0x06 (receive count) are ignored. A read of 0x06 returns the engine receive count input. A read of 0x01 returns the pin input, not the output register.
- R7: If select rises while a register write, register read, order or revision command still lacks bytes, the status register becomes 0xF9.
- R8: A command byte of 0x00, 0x01, 0x02, 0x08 or 0x09 is forwarded to the engine with the first flag set. Every later byte of that frame is forwarded with the flag clear, and one end pulse follows select rising.
- R9: An engine command that arrives while the engine busy input is high is dropped, and none of its bytes reach the engine.
- R10: After an unknown opcode, all bytes are ignored until select rises.
- R11: Raising select abandons a partly received command. Registers change only while selected, and the next frame starts at the opcode byte.
- R12: The MISO output enable is high only while select is low.
- R13: A status update pulse from the engine loads its value into the status register, and this takes priority over the 0xF9 code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from master, idles high |
| spi_mosi | input | 1 | Serial data from master |
| spi_csn | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO pad drive enable; pad is high-Z when low |
| gpio_in | input | 8 | Pin levels returned when address 0x01 is read |
| io_cfg_lo | output | 8 | Register 0x00, pin mode for pins 0-3 |
| io_out | output | 8 | Register 0x01, pin output levels |
| i2c_div | output | 8 | Register 0x02, I2C clock divider |
| i2c_tmo | output | 8 | Register 0x03, transaction timeout |
| own_addr | output | 8 | Register 0x05, own I2C address |
| io_cfg_hi | output | 8 | Register 0x07, pin mode for pins 4-7 |
| edge_cfg | output | 8 | Register 0x08, edge interrupt control |
| i2c_tmo2 | output | 8 | Register 0x09, extra bus timeouts |
| eng_busy | input | 1 | Engine is executing a transaction |
| eng_stat_we | input | 1 | Engine status update strobe |
| eng_stat | input | 8 | Engine status value |
| eng_rxcnt | input | 8 | Engine receive byte count |
| eng_byte_vld | output | 1 | Forwarded byte strobe |
| eng_first | output | 1 | Forwarded byte is the opcode |
| eng_byte | output | 8 | Forwarded byte value |
| eng_end | output | 1 | Forwarded command frame has ended |

## Verification
A decoder left in the wrong state shows up in the next frame. A stale sequencer drops or misplaces the next register write, or it returns read data one byte early or late on MISO. The bench catches this by reading back through the serial port right after each write, abort and unknown opcode. A wrong bit-order flag shows as a bit-reversed read value within the next byte. A forwarding error shows as a wrong byte count or a misplaced first flag on the engine stream a few system clocks after each byte ends.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int REG_COUNT = 10;
    localparam int BYTE_W    = 8;

    localparam logic [7:0] OP_REG_WR = 8'h20;
    localparam logic [7:0] OP_REG_RD = 8'h21;
    localparam logic [7:0] OP_ORDER  = 8'h18;
    localparam logic [7:0] OP_REV    = 8'h40;
    localparam logic [7:0] ORD_MSB   = 8'h81;
    localparam logic [7:0] ORD_LSB   = 8'h42;
    localparam logic [7:0] STAT_BAD  = 8'hF9;

    localparam int A_IOSTATE = 1;
    localparam int A_DIV     = 2;
    localparam int A_STATUS  = 4;
    localparam int A_RXCNT   = 6;

    typedef enum logic [3:0] {
        ST_CMD, ST_WADDR, ST_WDATA, ST_RADDR, ST_RDUMMY, ST_RDATA,
        ST_ORDER, ST_REVDUM, ST_REVHI, ST_REVLO, ST_FWD, ST_DROP
    } dec_state_e;

    typedef struct packed {
        logic       vld;
        logic       first;
        logic [7:0] data;
    } eng_beat_t;

    function automatic logic is_engine_op(input logic [7:0] op);
        return (op == 8'h00) || (op == 8'h01) || (op == 8'h02) ||
               (op == 8'h08) || (op == 8'h09);
    endfunction

    function automatic logic needs_more(input dec_state_e st);
        return (st == ST_WADDR) || (st == ST_WDATA) || (st == ST_RADDR) ||
               (st == ST_RDUMMY) || (st == ST_ORDER) || (st == ST_REVDUM);
    endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_raw,
    input  logic mosi_raw,
    input  logic csn_raw,
    output logic mosi_s,
    output logic csn_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic csn_rise
);
    logic [STAGES-1:0] sclk_q, mosi_q, csn_q;
    logic              sclk_prev, csn_prev, sclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= '1;
            csn_q     <= '1;
            mosi_q    <= '0;
            sclk_prev <= 1'b1;
            csn_prev  <= 1'b1;
        end else begin
            sclk_q    <= {sclk_q[STAGES-2:0], sclk_raw};
            csn_q     <= {csn_q[STAGES-2:0], csn_raw};
            mosi_q    <= {mosi_q[STAGES-2:0], mosi_raw};
            sclk_prev <= sclk_q[STAGES-1];
            csn_prev  <= csn_q[STAGES-1];
        end
    end

    assign sclk_s    = sclk_q[STAGES-1];
    assign csn_s     = csn_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];
    assign sclk_rise = sclk_s & ~sclk_prev & ~csn_s;
    assign sclk_fall = ~sclk_s & sclk_prev & ~csn_s;
    assign csn_rise  = csn_s & ~csn_prev;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              lsb_first,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_vld,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [CW-1:0]     rcnt, fcnt, tx_idx;
    logic [BYTE_W-1:0] rx_sh, sh_next, tx_work;

    always_comb begin
        sh_next = lsb_first ? {mosi_s, rx_sh[BYTE_W-1:1]}
                            : {rx_sh[BYTE_W-2:0], mosi_s};
        tx_idx  = lsb_first ? fcnt : LAST - fcnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt <= '0; fcnt <= '0; rx_sh <= '0; tx_work <= '0;
            rx_vld <= 1'b0; rx_byte <= '0; miso <= 1'b0;
        end else begin
            rx_vld <= 1'b0;
            if (csn_s) begin
                rcnt <= '0;
                fcnt <= '0;
                miso <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    rx_sh <= sh_next;
                    rcnt  <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
                    if (rcnt == LAST) begin
                        rx_vld  <= 1'b1;
                        rx_byte <= sh_next;
                    end
                end
                if (sclk_fall) begin
                    fcnt <= (fcnt == LAST) ? '0 : fcnt + 1'b1;
                    if (fcnt == '0) begin
                        tx_work <= tx_byte;
                        miso    <= lsb_first ? tx_byte[0] : tx_byte[BYTE_W-1];
                    end else begin
                        miso    <= tx_work[tx_idx];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
    import spi_cmd_pkg::*;
#(
    parameter logic [7:0] DIV_RESET = 8'hA0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic [7:0] gpio_in,
    input  logic [7:0] eng_rxcnt,
    input  logic       eng_stat_we,
    input  logic [7:0] eng_stat,
    input  logic       abort_err,
    output logic [7:0] status_q,
    output logic [7:0] regs [REG_COUNT]
);
    localparam int IW = $clog2(REG_COUNT);

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (i == A_RXCNT) begin : g_rx
            assign regs[i] = eng_rxcnt;
        end else if (i == A_STATUS) begin : g_st
            always_ff @(posedge clk) begin
                if (rst)              regs[i] <= 8'h00;
                else if (eng_stat_we) regs[i] <= eng_stat;
                else if (abort_err)   regs[i] <= STAT_BAD;
            end
        end else begin : g_rw
            localparam logic [7:0] RST_V = (i == A_DIV) ? DIV_RESET : 8'h00;
            always_ff @(posedge clk) begin
                if (rst)                                  regs[i] <= RST_V;
                else if (wr_en && wr_addr == 8'(i))       regs[i] <= wr_data;
            end
        end
    end

    assign status_q = regs[A_STATUS];

    always_comb begin
        if (rd_addr == 8'(A_IOSTATE))      rd_data = gpio_in;
        else if (rd_addr < 8'(REG_COUNT))  rd_data = regs[rd_addr[IW-1:0]];
        else                               rd_data = 8'h00;
    end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter logic [7:0] REV_HI = 8'h01,
    parameter logic [7:0] REV_LO = 8'h44
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_vld,
    input  logic [7:0] rx_byte,
    input  logic       csn_rise,
    input  logic       eng_busy,
    input  logic [7:0] rd_data,
    output logic [7:0] addr_q,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       lsb_first,
    output logic [7:0] tx_byte,
    output eng_beat_t  beat,
    output logic       eng_end,
    output logic       abort_err
);
    dec_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CMD; addr_q <= '0; wr_en <= 1'b0; wr_data <= '0;
            lsb_first <= 1'b0; tx_byte <= '0; beat <= '0;
            eng_end <= 1'b0; abort_err <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            beat.vld  <= 1'b0;
            eng_end   <= 1'b0;
            abort_err <= 1'b0;
            if (csn_rise) begin
                state     <= ST_CMD;
                tx_byte   <= '0;
                abort_err <= needs_more(state);
                eng_end   <= (state == ST_FWD);
            end else if (rx_vld) begin
                tx_byte <= '0;
                unique case (state)
                    ST_CMD: begin
                        if (rx_byte == OP_REG_WR)      state <= ST_WADDR;
                        else if (rx_byte == OP_REG_RD) state <= ST_RADDR;
                        else if (rx_byte == OP_ORDER)  state <= ST_ORDER;
                        else if (rx_byte == OP_REV)    state <= ST_REVDUM;
                        else if (is_engine_op(rx_byte) && !eng_busy) begin
                            beat  <= '{vld: 1'b1, first: 1'b1, data: rx_byte};
                            state <= ST_FWD;
                        end else                       state <= ST_DROP;
                    end
                    ST_WADDR:  begin addr_q <= rx_byte; state <= ST_WDATA; end
                    ST_WDATA:  begin wr_en <= 1'b1; wr_data <= rx_byte; state <= ST_DROP; end
                    ST_RADDR:  begin addr_q <= rx_byte; state <= ST_RDUMMY; end
                    ST_RDUMMY: begin tx_byte <= rd_data; state <= ST_RDATA; end
                    ST_ORDER: begin
                        if (rx_byte == ORD_MSB)      lsb_first <= 1'b0;
                        else if (rx_byte == ORD_LSB) lsb_first <= 1'b1;
                        state <= ST_DROP;
                    end
                    ST_REVDUM: begin tx_byte <= REV_HI; state <= ST_REVHI; end
                    ST_REVHI:  begin tx_byte <= REV_LO; state <= ST_REVLO; end
                    ST_FWD:    beat <= '{vld: 1'b1, first: 1'b0, data: rx_byte};
                    default:   state <= ST_DROP;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_cmd_regif.sv
module spi_cmd_regif
    import spi_cmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DIV_RESET   = 8'hA0,
    parameter logic [7:0] REV_HI      = 8'h01,
    parameter logic [7:0] REV_LO      = 8'h44
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    input  logic       spi_csn,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic [7:0] gpio_in,
    output logic [7:0] io_cfg_lo,
    output logic [7:0] io_out,
    output logic [7:0] i2c_div,
    output logic [7:0] i2c_tmo,
    output logic [7:0] own_addr,
    output logic [7:0] io_cfg_hi,
    output logic [7:0] edge_cfg,
    output logic [7:0] i2c_tmo2,
    input  logic       eng_busy,
    input  logic       eng_stat_we,
    input  logic [7:0] eng_stat,
    input  logic [7:0] eng_rxcnt,
    output logic       eng_byte_vld,
    output logic       eng_first,
    output logic [7:0] eng_byte,
    output logic       eng_end
);
    logic       mosi_s, csn_s, sclk_rise, sclk_fall, csn_rise;
    logic       rx_vld, lsb_first, wr_en, dec_abort;
    logic [7:0] rx_byte, tx_byte, addr_q, wr_data, rd_data, stat_q;
    logic [7:0] regs [REG_COUNT];
    eng_beat_t  beat;

    spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst, .sclk_raw(spi_sclk), .mosi_raw(spi_mosi), .csn_raw(spi_csn),
        .mosi_s, .csn_s, .sclk_rise, .sclk_fall, .csn_rise
    );

    spi_cmd_shifter u_shift (
        .clk, .rst, .csn_s, .sclk_rise, .sclk_fall, .mosi_s, .lsb_first,
        .tx_byte, .rx_vld, .rx_byte, .miso(spi_miso)
    );

    spi_cmd_decoder #(.REV_HI(REV_HI), .REV_LO(REV_LO)) u_dec (
        .clk, .rst, .rx_vld, .rx_byte, .csn_rise, .eng_busy, .rd_data,
        .addr_q, .wr_en, .wr_data, .lsb_first, .tx_byte, .beat,
        .eng_end, .abort_err(dec_abort)
    );

    spi_cmd_regfile #(.DIV_RESET(DIV_RESET)) u_regs (
        .clk, .rst, .wr_en, .wr_addr(addr_q), .wr_data, .rd_addr(addr_q),
        .rd_data, .gpio_in, .eng_rxcnt, .eng_stat_we, .eng_stat,
        .abort_err(dec_abort), .status_q(stat_q), .regs
    );

    assign spi_miso_oe  = ~csn_s;
    assign io_cfg_lo    = regs[0];
    assign io_out       = regs[1];
    assign i2c_div      = regs[2];
    assign i2c_tmo      = regs[3];
    assign own_addr     = regs[5];
    assign io_cfg_hi    = regs[7];
    assign edge_cfg     = regs[8];
    assign i2c_tmo2     = regs[9];
    assign eng_byte_vld = beat.vld;
    assign eng_first    = beat.first;
    assign eng_byte     = beat.data;
endmodule

// File: rtl/spi_cmd_regif_chk.sv
module spi_cmd_regif_chk (
    input logic       clk,
    input logic       rst,
    input logic       spi_csn,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic       csn_s,
    input logic       eng_busy,
    input logic       eng_byte_vld,
    input logic       eng_first,
    input logic       eng_end,
    input logic       eng_stat_we,
    input logic [7:0] eng_stat,
    input logic       dec_abort,
    input logic [7:0] stat_q,
    input logic [7:0] io_cfg_lo,
    input logic [7:0] io_out,
    input logic [7:0] i2c_div,
    input logic [7:0] i2c_tmo,
    input logic [7:0] own_addr,
    input logic [7:0] io_cfg_hi,
    input logic [7:0] edge_cfg,
    input logic [7:0] i2c_tmo2
);
    logic [63:0] wregs;
    assign wregs = {io_cfg_lo, io_out, i2c_div, i2c_tmo, own_addr, io_cfg_hi, edge_cfg, i2c_tmo2};

    p_one_reg_per_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({io_cfg_lo != $past(io_cfg_lo), io_out != $past(io_out),
                    i2c_div != $past(i2c_div), i2c_tmo != $past(i2c_tmo),
                    own_addr != $past(own_addr), io_cfg_hi != $past(io_cfg_hi),
                    edge_cfg != $past(edge_cfg), i2c_tmo2 != $past(i2c_tmo2)}) <= 1);

    p_quiet_when_desel_r11: assert property (@(posedge clk) disable iff (rst)
        (csn_s && $past(csn_s)) |-> $stable(wregs));

    p_oe_off_desel_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso_oe);

    p_miso_known_r12: assert property (@(posedge clk) disable iff (rst)
        spi_miso_oe |-> !$isunknown(spi_miso));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (eng_byte_vld && eng_first) |-> !$past(eng_busy));

    p_end_after_desel_r8: assert property (@(posedge clk) disable iff (rst)
        eng_end |-> (csn_s && !eng_byte_vld));

    p_abort_status_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_abort && !eng_stat_we) |=> (stat_q == 8'hF9));

    p_eng_status_r13: assert property (@(posedge clk) disable iff (rst)
        eng_stat_we |=> (stat_q == $past(eng_stat)));
endmodule

bind spi_cmd_regif spi_cmd_regif_chk chk_i (
    .clk, .rst, .spi_csn, .spi_miso, .spi_miso_oe, .csn_s, .eng_busy,
    .eng_byte_vld, .eng_first, .eng_end, .eng_stat_we, .eng_stat,
    .dec_abort, .stat_q, .io_cfg_lo, .io_out, .i2c_div, .i2c_tmo,
    .own_addr, .io_cfg_hi, .edge_cfg, .i2c_tmo2
);

// File: tb/spi_cmd_regif_tb_top.sv
module spi_cmd_regif_tb_top;
    logic clk = 1'b0, rst = 1'b1;
    logic spi_sclk = 1'b1, spi_mosi = 1'b0, spi_csn = 1'b1;
    logic spi_miso, spi_miso_oe;
    logic [7:0] gpio_in = 8'h00;
    logic [7:0] io_cfg_lo, io_out, i2c_div, i2c_tmo, own_addr, io_cfg_hi, edge_cfg, i2c_tmo2;
    logic eng_busy = 1'b0, eng_stat_we = 1'b0;
    logic [7:0] eng_stat = 8'h00, eng_rxcnt = 8'h00;
    logic eng_byte_vld, eng_first, eng_end;
    logic [7:0] eng_byte;

    int n_chk = 0, n_fail = 0, n_beats = 0, n_end = 0;
    logic [7:0] beat_data [8];
    logic       beat_first [8];
    logic master_lsb = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    spi_cmd_regif dut_i (.*);

    always @(posedge clk) begin
        if (!rst) begin
            if (eng_byte_vld) begin
                beat_data[n_beats % 8]  <= eng_byte;
                beat_first[n_beats % 8] <= eng_first;
                n_beats <= n_beats + 1;
            end
            if (eng_end) n_end <= n_end + 1;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < 8; i++) begin
            int bi = master_lsb ? i : 7 - i;
            @(negedge clk); spi_sclk = 1'b0; spi_mosi = tx[bi];
            repeat (10) @(negedge clk);
            rx[bi] = spi_miso;
            spi_sclk = 1'b1;
            repeat (10) @(negedge clk);
        end
    endtask

    task automatic sel();
        @(negedge clk); spi_csn = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic desel();
        repeat (6) @(negedge clk);
        spi_csn = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel(); spi_byte(8'h20, d); spi_byte(a, d); spi_byte(v, d); desel();
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] d;
        sel(); spi_byte(8'h21, d); spi_byte(a, d); spi_byte(8'hE7, d); spi_byte(8'h00, v); desel();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 div reset", i2c_div, 8'hA0);
        chk("R1 own_addr reset", own_addr, 8'h00);
        chk("R1 io_out reset", io_out, 8'h00);
        chk("R12 oe idle", {7'd0, spi_miso_oe}, 8'h00);
        reg_rd(8'h02, v);
        chk("R1 R3 div readback", v, 8'hA0);
    endtask

    task automatic t_write_read();
        logic [7:0] v, d;
        reg_wr(8'h05, 8'h5A);
        chk("R2 own_addr written", own_addr, 8'h5A);
        chk("R2 div untouched", i2c_div, 8'hA0);
        chk("R2 cfg_hi untouched", io_cfg_hi, 8'h00);
        reg_wr(8'h01, 8'hC3);
        chk("R2 io_out written", io_out, 8'hC3);
        sel();
        chk("R12 oe while selected", {7'd0, spi_miso_oe}, 8'h01);
        spi_byte(8'h21, d); spi_byte(8'h05, d); spi_byte(8'h00, d); spi_byte(8'h00, v);
        desel();
        chk("R3 read own_addr", v, 8'h5A);
        chk("R12 oe after deselect", {7'd0, spi_miso_oe}, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] v, d;
        sel(); spi_byte(8'h18, d); spi_byte(8'h42, d); desel();
        master_lsb = 1'b1;
        reg_rd(8'h05, v);
        chk("R4 lsb-first read", v, 8'h5A);
        reg_wr(8'h03, 8'h0F);
        chk("R4 lsb-first write", i2c_tmo, 8'h0F);
        sel(); spi_byte(8'h18, d); spi_byte(8'h55, d); desel();
        reg_rd(8'h03, v);
        chk("R4 bad order value ignored", v, 8'h0F);
        sel(); spi_byte(8'h18, d); spi_byte(8'h81, d); desel();
        master_lsb = 1'b0;
        reg_rd(8'h05, v);
        chk("R4 back to msb-first", v, 8'h5A);
    endtask

    task automatic t_rev();
        logic [7:0] d, hi, lo;
        sel(); spi_byte(8'h40, d); spi_byte(8'h00, d); spi_byte(8'h00, hi); spi_byte(8'h00, lo); desel();
        chk("R5 revision high", hi, 8'h01);
        chk("R5 revision low", lo, 8'h44);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        eng_rxcnt = 8'h37; gpio_in = 8'h96;
        reg_wr(8'h06, 8'h11);
        reg_rd(8'h06, v);
        chk("R6 rx count from input", v, 8'h37);
        reg_wr(8'h04, 8'h22);
        reg_rd(8'h04, v);
        chk("R6 status not writable", v, 8'h00);
        reg_rd(8'h01, v);
        chk("R6 pin state read", v, 8'h96);
        chk("R6 io_out kept", io_out, 8'hC3);
    endtask

    task automatic t_abort();
        logic [7:0] v, d;
        sel(); spi_byte(8'h20, d); spi_byte(8'h05, d); desel();
        chk("R11 aborted write no effect", own_addr, 8'h5A);
        reg_rd(8'h04, v);
        chk("R7 truncated status", v, 8'hF9);
        reg_wr(8'h05, 8'h77);
        chk("R11 next frame from opcode", own_addr, 8'h77);
    endtask

    task automatic t_unknown();
        logic [7:0] d;
        sel(); spi_byte(8'h77, d); spi_byte(8'h20, d); spi_byte(8'h05, d); spi_byte(8'h33, d); desel();
        chk("R10 unknown opcode swallows frame", own_addr, 8'h77);
    endtask

    task automatic t_eng_stat();
        logic [7:0] v;
        @(negedge clk); eng_stat = 8'hF0; eng_stat_we = 1'b1;
        @(negedge clk); eng_stat_we = 1'b0;
        reg_rd(8'h04, v);
        chk("R13 engine status loaded", v, 8'hF0);
    endtask

    task automatic t_forward();
        logic [7:0] d;
        int b0, e0;
        b0 = n_beats; e0 = n_end;
        sel();
        spi_byte(8'h00, d); spi_byte(8'h02, d); spi_byte(8'h50, d); spi_byte(8'hAB, d); spi_byte(8'hCD, d);
        desel();
        chk("R8 beat count", 8'(n_beats - b0), 8'd5);
        chk("R8 first beat value", beat_data[b0 % 8], 8'h00);
        chk("R8 first flag set", {7'd0, beat_first[b0 % 8]}, 8'h01);
        chk("R8 last beat value", beat_data[(b0 + 4) % 8], 8'hCD);
        chk("R8 later flag clear", {7'd0, beat_first[(b0 + 4) % 8]}, 8'h00);
        chk("R8 one end pulse", 8'(n_end - e0), 8'd1);
        chk("R8 registers untouched", own_addr, 8'h77);
    endtask

    task automatic t_busy();
        logic [7:0] d;
        int b0, e0;
        b0 = n_beats; e0 = n_end;
        eng_busy = 1'b1;
        sel(); spi_byte(8'h01, d); spi_byte(8'h50, d); spi_byte(8'h03, d); desel();
        eng_busy = 1'b0;
        chk("R9 busy drops beats", 8'(n_beats - b0), 8'd0);
        chk("R9 busy no end pulse", 8'(n_end - e0), 8'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_order();
        t_rev();
        t_readonly();
        t_abort();
        t_unknown();
        t_eng_stat();
        t_forward();
        t_busy();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule